// File: doc/BRIEF.md
# Store Data Formatter with Byte Reversal

This block sits between the register read stage and a 16-byte-wide store path. For each store it takes the source register value, and for quadword stores the odd partner of an even-odd register pair, and lays the bytes out in memory order. It produces the data for the doubleword at the effective address, the data for the doubleword eight bytes above it, a 16-bit byte enable and an invalid-form flag. Address generation, the cache port and all other exceptions are handled elsewhere.

Five access sizes are supported: byte, halfword, word, doubleword and quadword. A byte-reverse select turns halfword, word and doubleword stores into their byte-swapped forms. The endian mode only matters for quadword stores. There it sets which register of the pair goes to which doubleword, and whether the bytes of each register are reversed. The result is registered, so it appears one clock after the request.

Register bytes are numbered from the most significant end: register bits 0:7 are port bits [63:56]. On both data outputs, byte lane k is port bits [8k+7:8k]. Lane k of `lo_data` is the byte at EA+k, and lane k of `hi_data` is the byte at EA+8+k. Bit k of `byte_en` enables the byte at EA+k. Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword and 4 quadword. Codes 5 to 7 are reserved.

Top module: `sfmt_store_fmt`

## Requirements
- R1: A byte store (size 0) puts register bits 56:63 (port bits [7:0]) in lane 0 of `lo_data` and sets only `byte_en` bit 0.
- R2: A halfword store (size 0x1) with reverse low puts register bits 48:55 in lane 0 and bits 56:63 in lane 1, and enables lanes 0 to 1.
- R3: A word store (size 2) with reverse low puts register bits 32:63 in lanes 0 to 3, most significant byte first, and enables lanes 0 to 3.
- R4: A doubleword store (size 3) with reverse low puts register bits 8k:8k+7 in lane k for k = 0 to 7, and enables lanes 0 to 7.
- R5: With reverse high, a halfword, word or doubleword store of N bytes puts register bits (56-8k):(63-8k) in lane k for k < N. Register bits 56:63 go to lane 0 and the most significant covered byte goes to lane N-1.
- R6: The reverse select has no effect on byte and quadword stores.
- R7: A quadword store (size 4) with an even index in big-endian mode (`little_endian` low) puts the even register in `lo_data` and the odd register in `hi_data`, each in the R4 order, and sets all 16 enables.
- R8: A quadword store with an even index in little-endian mode puts the odd register in `lo_data` and the even register in `hi_data`, each in the R5 order, and sets all 16 enables.
- R9: A quadword store with an odd `src_idx` raises `bad_form`, clears all enables and drives both data outputs to zero.
- R10: Size codes 5, 6 and 7 raise `bad_form`, clear all enables and drive both data outputs to zero.
- R11: For sizes 0 to 3, lanes at or above the access size and all of `hi_data` are zero, and `little_endian` has no effect.
- R12: Results appear one clock after the request, with `out_valid` matching the previous cycle's `in_valid`. While `out_valid` is low, and after reset, `byte_en` is zero and `bad_form` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Store request present this cycle |
| acc_size | input | 3 | Access size code (0 byte, 1 half, 2 word, 3 dword, 4 quad) |
| byte_rev | input | 1 | Byte-reversed store select |
| little_endian | input | 1 | Endian mode, 1 = little-endian |
| src_idx | input | 5 | Source register index |
| src_data | input | 64 | Source register value (even register for quadword) |
| pair_data | input | 64 | Odd register of the pair (quadword only) |
| out_valid | output | 1 | Formatted result present |
| lo_data | output | 64 | Bytes for EA to EA+7, lane k at bits [8k+7:8k] |
| hi_data | output | 64 | Bytes for EA+8 to EA+15 |
| byte_en | output | 16 | Byte enable, bit k for EA+k |
| bad_form | output | 1 | Invalid form detected |

## Verification
The hardest cases to reach are the ones where a control input must make no difference. Examples are a reverse select on a quadword or byte store, an endian mode on a narrow store, and an idle cycle whose inputs would form an odd-pair quadword. The bench sweeps every size code, both reverse and endian settings, even and odd register indices, and data patterns whose bytes are all distinct. This way any swapped or misplaced lane shows up in the result. Idle cycles carrying invalid-looking inputs are checked to show that no enable or flag leaks out.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
    parameter int unsigned REG_BYTES = 8;
    localparam int unsigned REG_W    = REG_BYTES * 8;
    localparam int unsigned LINE_B   = REG_BYTES * 2;
    localparam int unsigned NB_W     = $clog2(REG_BYTES) + 1;
    localparam int unsigned EN_CNT_W = $clog2(LINE_B) + 1;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DWORD = 3'd3,
        SZ_QUAD  = 3'd4
    } acc_size_e;

    typedef struct packed {
        logic              vld;
        logic [REG_W-1:0]  lo;
        logic [REG_W-1:0]  hi;
        logic [LINE_B-1:0] be;
        logic              bad;
    } fmt_state_t;
endpackage

// File: rtl/sfmt_lane_pick.sv
module sfmt_lane_pick #(
    parameter int unsigned BYTES = 8,
    localparam int unsigned CNT_W = $clog2(BYTES) + 1,
    localparam int unsigned SEL_W = $clog2(BYTES)
) (
    input  logic [BYTES*8-1:0] reg_val,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic               reverse,
    output logic [BYTES*8-1:0] lanes
);
    // Lane k receives register byte k (LSB numbering) when reversed,
    // otherwise byte nbytes-1-k; lanes beyond nbytes are zero.
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        logic [SEL_W-1:0] sel;
        logic             used;
        assign used = (CNT_W'(k) < nbytes);
        assign sel  = reverse ? SEL_W'(k)
                              : SEL_W'(nbytes - CNT_W'(k) - CNT_W'(1));
        assign lanes[k*8 +: 8] = used ? reg_val[{sel, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/sfmt_enable_gen.sv
module sfmt_enable_gen #(
    parameter int unsigned LANES = 16,
    localparam int unsigned CNT_W = $clog2(LANES) + 1
) (
    input  logic [CNT_W-1:0] count,
    input  logic             block,
    output logic [LANES-1:0] en
);
    for (genvar k = 0; k < LANES; k++) begin : g_en
        assign en[k] = !block && (CNT_W'(k) < count);
    end
endmodule

// File: rtl/sfmt_store_fmt.sv
module sfmt_store_fmt
    import sfmt_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        acc_size,
    input  logic              byte_rev,
    input  logic              little_endian,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [REG_W-1:0]  src_data,
    input  logic [REG_W-1:0]  pair_data,
    output logic              out_valid,
    output logic [REG_W-1:0]  lo_data,
    output logic [REG_W-1:0]  hi_data,
    output logic [LINE_B-1:0] byte_en,
    output logic              bad_form
);
    fmt_state_t state_d, state_q;

    logic [NB_W-1:0]     nb_sel;
    logic                rev_sel;
    logic                is_quad;
    logic                form_bad;
    logic [EN_CNT_W-1:0] en_count;
    logic [REG_W-1:0]    src_lanes;
    logic [REG_W-1:0]    pair_lanes;
    logic [LINE_B-1:0]   en_vec;

    // Decode of size, reversal and form validity.
    always_comb begin
        nb_sel   = '0;
        rev_sel  = 1'b0;
        is_quad  = 1'b0;
        form_bad = 1'b0;
        case (acc_size_e'(acc_size))
            SZ_BYTE: begin
                nb_sel = NB_W'(1);
            end
            SZ_HALF: begin
                nb_sel  = NB_W'(2);
                rev_sel = byte_rev;
            end
            SZ_WORD: begin
                nb_sel  = NB_W'(4);
                rev_sel = byte_rev;
            end
            SZ_DWORD: begin
                nb_sel  = NB_W'(REG_BYTES);
                rev_sel = byte_rev;
            end
            SZ_QUAD: begin
                nb_sel   = NB_W'(REG_BYTES);
                rev_sel  = little_endian;
                is_quad  = 1'b1;
                form_bad = src_idx[0];
            end
            default: begin
                form_bad = 1'b1;
            end
        endcase
        en_count = is_quad ? EN_CNT_W'(LINE_B) : EN_CNT_W'(nb_sel);
    end

    sfmt_lane_pick #(.BYTES(REG_BYTES)) u_src_pick (
        .reg_val (src_data),
        .nbytes  (nb_sel),
        .reverse (rev_sel),
        .lanes   (src_lanes)
    );

    sfmt_lane_pick #(.BYTES(REG_BYTES)) u_pair_pick (
        .reg_val (pair_data),
        .nbytes  (NB_W'(REG_BYTES)),
        .reverse (little_endian),
        .lanes   (pair_lanes)
    );

    sfmt_enable_gen #(.LANES(LINE_B)) u_en_gen (
        .count (en_count),
        .block (form_bad || !in_valid),
        .en    (en_vec)
    );

    // Next-state assembly.
    always_comb begin
        state_d     = '0;
        state_d.vld = in_valid;
        state_d.bad = in_valid && form_bad;
        state_d.be  = en_vec;
        if (in_valid && !form_bad) begin
            if (is_quad) begin
                state_d.lo = little_endian ? pair_lanes : src_lanes;
                state_d.hi = little_endian ? src_lanes  : pair_lanes;
            end else begin
                state_d.lo = src_lanes;
                state_d.hi = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign lo_data   = state_q.lo;
    assign hi_data   = state_q.hi;
    assign byte_en   = state_q.be;
    assign bad_form  = state_q.bad;
endmodule

// File: rtl/sfmt_store_fmt_chk.sv
module sfmt_store_fmt_chk #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned REG_W = 64,
    parameter int unsigned LINE_B = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        acc_size,
    input logic [IDX_W-1:0]  src_idx,
    input logic              out_valid,
    input logic [REG_W-1:0]  hi_data,
    input logic [LINE_B-1:0] byte_en,
    input logic              bad_form
);
    // R9
    a_r9_odd_pair_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && acc_size == 3'd4 && src_idx[0] |=> bad_form && byte_en == '0);

    // R10
    a_r10_reserved_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && acc_size > 3'd4 |=> bad_form && byte_en == '0);

    // R7
    a_r7_quad_full_enable: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && acc_size == 3'd4 && !src_idx[0] |=> byte_en == '1 && !bad_form);

    // R11
    a_r11_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && acc_size < 3'd4 |=> hi_data == '0);

    // R12
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r12_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> byte_en == '0 && !bad_form);

    // R1..R4: enable count is always a legal access size
    a_r1_enable_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !bad_form |->
            ($countones(byte_en) == 1 || $countones(byte_en) == 2 ||
             $countones(byte_en) == 4 || $countones(byte_en) == 8 ||
             $countones(byte_en) == 16));
endmodule

bind sfmt_store_fmt sfmt_store_fmt_chk #(
    .IDX_W (IDX_W),
    .REG_W (sfmt_pkg::REG_W),
    .LINE_B(sfmt_pkg::LINE_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_size  (acc_size),
    .src_idx   (src_idx),
    .out_valid (out_valid),
    .hi_data   (hi_data),
    .byte_en   (byte_en),
    .bad_form  (bad_form)
);

// File: tb/sfmt_store_fmt_tb_top.sv
module sfmt_store_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  acc_size;
    logic        byte_rev;
    logic        little_endian;
    logic [4:0]  src_idx;
    logic [63:0] src_data;
    logic [63:0] pair_data;
    logic        out_valid;
    logic [63:0] lo_data;
    logic [63:0] hi_data;
    logic [15:0] byte_en;
    logic        bad_form;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sfmt_store_fmt dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .acc_size      (acc_size),
        .byte_rev      (byte_rev),
        .little_endian (little_endian),
        .src_idx       (src_idx),
        .src_data      (src_data),
        .pair_data     (pair_data),
        .out_valid     (out_valid),
        .lo_data       (lo_data),
        .hi_data       (hi_data),
        .byte_en       (byte_en),
        .bad_form      (bad_form)
    );

    function automatic logic [63:0] bswap(input logic [63:0] x);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = x[(7-i)*8 +: 8];
        return r;
    endfunction

    function automatic string req_tag(input int sz, input bit rv, input bit le, input bit odd);
        if (sz > 4) return "R10";
        if (sz == 4 && odd) return "R9";
        if (sz == 4) return rv ? "R6" : (le ? "R8" : "R7");
        if (le) return "R11";
        if (sz == 0) return rv ? "R6" : "R1";
        if (rv) return "R5";
        if (sz == 1) return "R2";
        if (sz == 2) return "R3";
        return "R4";
    endfunction

    task automatic check_flag(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: flag actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int sz, input bit rv, input bit le, input logic [4:0] idx,
                           input logic [63:0] s, input logic [63:0] p);
        logic [63:0] e_lo, e_hi, masked;
        logic [15:0] e_be;
        logic        e_bad;
        int          nb;
        string       tag;
        in_valid      = 1'b1;
        acc_size      = 3'(sz);
        byte_rev      = rv;
        little_endian = le;
        src_idx       = idx;
        src_data      = s;
        pair_data     = p;
        e_bad = (sz > 4) || (sz == 4 && idx[0]);
        e_lo = '0; e_hi = '0; e_be = '0;
        if (!e_bad) begin
            if (sz == 4) begin
                e_be = 16'hFFFF;
                if (le) begin e_lo = p; e_hi = s; end
                else begin e_lo = bswap(s); e_hi = bswap(p); end
            end else begin
                nb = 1 << sz;
                masked = (nb == 8) ? s : (s & ((64'd1 << (8*nb)) - 64'd1));
                e_lo = (rv && sz != 0) ? masked : bswap(s << (64 - 8*nb));
                e_be = 16'((17'd1 << nb) - 17'd1);
            end
        end
        tag = req_tag(sz, rv, le, idx[0]);
        @(negedge clk);
        n_chk++;
        if (lo_data !== e_lo || hi_data !== e_hi || byte_en !== e_be || bad_form !== e_bad) begin
            n_fail++;
            $display("FAIL %s: sz=%0d rev=%0d le=%0d idx=%0d actual lo=%h hi=%h be=%h bad=%b expected lo=%h hi=%h be=%h bad=%b",
                     tag, sz, rv, le, idx, lo_data, hi_data, byte_en, bad_form, e_lo, e_hi, e_be, e_bad);
        end
        check_flag("R12 valid latency", out_valid, 1'b1);
    endtask

    task automatic run_idle(input int sz, input logic [4:0] idx);
        in_valid = 1'b0;
        acc_size = 3'(sz);
        src_idx  = idx;
        @(negedge clk);
        check_flag("R12 idle out_valid", out_valid, 1'b0);
        check_flag("R12 idle bad_form", bad_form, 1'b0);
        n_chk++;
        if (byte_en !== 16'h0000) begin
            n_fail++;
            $display("FAIL R12 idle byte_en actual=%h expected=0000", byte_en);
        end
    endtask

    initial begin
        logic [4:0]  idx_set [4];
        logic [63:0] s_set [3];
        logic [63:0] p_set [3];
        idx_set = '{5'd0, 5'd1, 5'd2, 5'd31};
        s_set   = '{64'h0123456789ABCDEF, 64'h8899AABBCCDDEEFF, 64'h80000000000000FF};
        p_set   = '{64'hFEDCBA9876543210, 64'h1122334455667788, 64'h7F00FF0000FF0001};
        rst_n = 1'b0; in_valid = 1'b1; acc_size = 3'd4; byte_rev = 1'b0;
        little_endian = 1'b0; src_idx = 5'd1; src_data = '1; pair_data = '1;
        repeat (3) @(negedge clk);
        check_flag("R12 reset out_valid", out_valid, 1'b0);
        check_flag("R12 reset bad_form", bad_form, 1'b0);
        n_chk++;
        if (byte_en !== 16'h0000) begin
            n_fail++;
            $display("FAIL R12 reset byte_en actual=%h expected=0000", byte_en);
        end
        rst_n = 1'b1;
        run_idle(4, 5'd1);
        run_idle(7, 5'd0);
        for (int sz = 0; sz < 8; sz++)
            for (int rv = 0; rv < 2; rv++)
                for (int le = 0; le < 2; le++)
                    for (int ix = 0; ix < 4; ix++)
                        for (int pt = 0; pt < 3; pt++)
                            run_vec(sz, rv[0], le[0], idx_set[ix], s_set[pt], p_set[pt]);
        run_idle(5, 5'd3);
        run_vec(4, 1'b0, 1'b1, 5'd6, 64'h0011223344556677, 64'h8899AABBCCDDEEFF);
        run_idle(2, 5'd0);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule